// File: doc/BRIEF.md
# Registered Command and Address Buffer with Parity Check

This block is a one-clock register stage placed in the path of a memory command and address bus. On every rising clock edge it captures the incoming bits and presents them on registered outputs. A two-bit mode input picks how the inputs map to the outputs. One mode is a straight 25-to-25 register. Two modes copy a narrower 14-bit input set onto 28 outputs, each input bit driving a lower and an upper output. These two copy modes differ in which three of the 14 bits form the command group. The fourth code is reserved. It behaves like the straight register and latches a sticky configuration-error flag.

Two active-low chip-select inputs control a freeze. When both are high, the ordinary data outputs keep their previous values. The clock-enable, termination and registered chip-select outputs still update, and so does the command group in the copy modes.

A parity bit for each captured word arrives on the clock after that word. The block XORs this bit with the covered data bits of the word, which it holds for one clock. It registers the result as a partial-parity output and as an active-low error flag. Both appear one clock after the data outputs of that word. A word that was captured with both selects high is not checked.

Top module: `cmdbuf_reg`

## Requirements
- R1: While `rst_n` is low, `q_data`, `q_cke`, `q_odt`, `q_cs`, `ppo` and `cfg_err` read 0 and `err_n` reads 1.
- R2: With `cfg_mode` = 2'b00 and at least one select low, a rising edge loads `q_data[24:0]` from `din[24:0]` and loads 0 into `q_data[27:25]`.
- R3: With `cfg_mode` = 2'b01 and at least one select low, a rising edge loads both `q_data[i]` and `q_data[i+14]` from `din[i]` for i = 0..13. `din[24:14]` is ignored.
- R4: With `cfg_mode` = 2'b11 and at least one select low, the mapping is the same as in R3.
- R5: When `cs0_n` and `cs1_n` are both high at an edge, every `q_data` bit outside the command group keeps its value. In modes 00 and 10 there is no command group.
- R6: In mode 01 the command group is input bits 0..2, driving `q_data[2:0]` and `q_data[16:14]`. In mode 11 it is input bits 11..13, driving `q_data[13:11]` and `q_data[27:25]`. These bits load as in R3 even when both selects are high.
- R7: At every edge, `q_cke` loads `cke_in`, `q_odt` loads `odt_in`, and `q_cs` loads {`cs1_n`, `cs0_n`}, whatever the select levels are.
- R8: Let a word be captured at edge k with at least one select low. At edge k+1, `ppo` loads the XOR of `par_in` with that word's covered bits: `din[24:0]` in modes 00 and 10, and `din[13:0]` in modes 01 and 11. If the word was captured with both selects high, `ppo` holds its value.
- R9: At edge k+1, for a word checked under R8, `err_n` loads the inverse of the new `ppo`. After an unchecked word, `err_n` loads 1.
- R10: `cfg_mode` = 2'b10 maps the data as in R2. An edge in this mode sets `cfg_err`, which stays 1 until reset.
- R11: Driving `rst_n` low clears all outputs to the R1 values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Mapping select: 00 flat, 01 copy with low command group, 11 copy with high command group, 10 reserved |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cke_in | input | 1 | Clock-enable input, never frozen |
| odt_in | input | 1 | Termination-control input, never frozen |
| din | input | 25 | Address and command data |
| par_in | input | 1 | Parity bit for the word captured one clock earlier |
| q_data | output | 28 | Registered data outputs |
| q_cke | output | 1 | Registered clock enable |
| q_odt | output | 1 | Registered termination control |
| q_cs | output | 2 | Registered selects {cs1_n, cs0_n} |
| ppo | output | 1 | Partial parity of the checked word and its parity bit |
| err_n | output | 1 | Parity error, active low |
| cfg_err | output | 1 | Sticky flag for a reserved mode code |

## Verification
The two functions that collide are the select freeze and the delayed parity check. The parity for a selected word arrives on the same edge at which the selects go high and freeze the data outputs. The stimulus table contains this case: a selected word is followed by a row with both selects high and a parity bit. The bench requires `q_data` to hold while `ppo` and `err_n` still report on the earlier word. It also requires that the frozen word itself is skipped on the following edge. In the copy modes the frozen row also exercises the command group, which must keep loading while the rest of the outputs hold.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

   typedef enum logic [1:0] {
      MODE_FLAT       = 2'b00,
      MODE_DUP_LOWCMD = 2'b01,
      MODE_RESERVED   = 2'b10,
      MODE_DUP_HICMD  = 2'b11
   } cb_mode_e;

   function automatic logic is_dup(input logic [1:0] m);
      return m[0];
   endfunction

   function automatic logic is_hicmd(input logic [1:0] m);
      return m[0] & m[1];
   endfunction

endpackage

// File: rtl/cmdbuf_route.sv
module cmdbuf_route #(
   parameter int DATA_W   = 25,
   parameter int NARROW_W = 14,
   parameter int CMD_W    = 3,
   parameter int OUT_W    = 28
) (
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] din,
   output logic [OUT_W-1:0]  next_q,
   output logic [OUT_W-1:0]  keep_mask,
   output logic [DATA_W-1:0] cov_word,
   output logic              rsvd
);
   import cmdbuf_pkg::*;

   logic [OUT_W-1:0]  flat_v;
   logic [OUT_W-1:0]  dup_v;
   logic [OUT_W-1:0]  lowk;
   logic [OUT_W-1:0]  hik;
   logic [DATA_W-1:0] narrow_mask;

   genvar i;
   generate
      for (i = 0; i < OUT_W; i++) begin : g_out
         localparam int J = i % NARROW_W;
         if (i < DATA_W) begin : g_flat
            assign flat_v[i] = din[i];
         end else begin : g_pad
            assign flat_v[i] = 1'b0;
         end
         if (i < 2*NARROW_W) begin : g_dup
            assign dup_v[i] = din[J];
            assign lowk[i]  = (J < CMD_W) ? 1'b1 : 1'b0;
            assign hik[i]   = (J >= NARROW_W - CMD_W) ? 1'b1 : 1'b0;
         end else begin : g_nodup
            assign dup_v[i] = 1'b0;
            assign lowk[i]  = 1'b0;
            assign hik[i]   = 1'b0;
         end
      end
      for (i = 0; i < DATA_W; i++) begin : g_cov
         assign narrow_mask[i] = (i < NARROW_W) ? 1'b1 : 1'b0;
      end
   endgenerate

   always_comb begin
      rsvd = (mode == MODE_RESERVED);
      if (is_dup(mode)) begin
         next_q    = dup_v;
         keep_mask = is_hicmd(mode) ? hik : lowk;
         cov_word  = din & narrow_mask;
      end else begin
         next_q    = flat_v;
         keep_mask = '0;
         cov_word  = din;
      end
   end

endmodule

// File: rtl/cmdbuf_dreg.sv
module cmdbuf_dreg #(
   parameter int OUT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frozen,
   input  logic [OUT_W-1:0] next_q,
   input  logic [OUT_W-1:0] keep_mask,
   output logic [OUT_W-1:0] q
);
   logic [OUT_W-1:0] load_mask;

   always_comb load_mask = frozen ? keep_mask : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (next_q & load_mask) | (q & ~load_mask);
   end

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> ((q & ~$past(keep_mask)) == ($past(q) & ~$past(keep_mask)))); // R5

   AST_CMD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> ((q & $past(keep_mask)) == ($past(next_q) & $past(keep_mask)))); // R6

endmodule

// File: rtl/cmdbuf_ctl.sv
module cmdbuf_ctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke_in,
   input  logic       odt_in,
   input  logic [1:0] cs_n,
   input  logic       rsvd,
   output logic       q_cke,
   output logic       q_odt,
   output logic [1:0] q_cs,
   output logic       cfg_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_cke   <= 1'b0;
         q_odt   <= 1'b0;
         q_cs    <= 2'b00;
         cfg_err <= 1'b0;
      end else begin
         q_cke   <= cke_in;
         q_odt   <= odt_in;
         q_cs    <= cs_n;
         cfg_err <= cfg_err | rsvd;
      end
   end

   AST_CTL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (q_cs == $past(cs_n) && q_cke == $past(cke_in))); // R7

   AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err); // R10

endmodule

// File: rtl/cmdbuf_parity.sv
module cmdbuf_parity #(
   parameter int DATA_W = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] cov_word,
   input  logic              word_sel,
   input  logic              par_in,
   output logic              ppo,
   output logic              err_n
);
   logic [DATA_W-1:0] held_word;
   logic              held_sel;
   logic              sum;

   always_comb sum = ^{held_word, par_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_word <= '0;
         held_sel  <= 1'b0;
         ppo       <= 1'b0;
         err_n     <= 1'b1;
      end else begin
         held_word <= cov_word;
         held_sel  <= word_sel;
         if (held_sel) begin
            ppo   <= sum;
            err_n <= ~sum;
         end else begin
            err_n <= 1'b1;
         end
      end
   end

   AST_ERR_MATCHES_PPO: assert property (@(posedge clk) disable iff (!rst_n)
      !err_n |-> ppo); // R9

   AST_UNSEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !held_sel |=> ($stable(ppo) && err_n)); // R8

   AST_RESET_ERR_HIGH: assert property (@(posedge clk)
      !rst_n |-> (err_n && !ppo)); // R1

endmodule

// File: rtl/cmdbuf_reg.sv
module cmdbuf_reg #(
   parameter int DATA_W   = 25,
   parameter int NARROW_W = 14,
   parameter int CMD_W    = 3,
   localparam int OUT_W   = (DATA_W > 2*NARROW_W) ? DATA_W : 2*NARROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic              cs0_n,
   input  logic              cs1_n,
   input  logic              cke_in,
   input  logic              odt_in,
   input  logic [DATA_W-1:0] din,
   input  logic              par_in,
   output logic [OUT_W-1:0]  q_data,
   output logic              q_cke,
   output logic              q_odt,
   output logic [1:0]        q_cs,
   output logic              ppo,
   output logic              err_n,
   output logic              cfg_err
);
   import cmdbuf_pkg::*;

   generate
      if (NARROW_W > DATA_W) begin : g_chk_narrow
         $error("NARROW_W must not exceed DATA_W");
      end
      if (CMD_W < 1 || CMD_W > NARROW_W) begin : g_chk_cmd
         $error("CMD_W must lie in 1..NARROW_W");
      end
   endgenerate

   logic              frozen;
   logic [OUT_W-1:0]  next_q;
   logic [OUT_W-1:0]  keep_mask;
   logic [DATA_W-1:0] cov_word;
   logic              rsvd;

   always_comb frozen = cs0_n & cs1_n;

   cmdbuf_route #(
      .DATA_W(DATA_W), .NARROW_W(NARROW_W), .CMD_W(CMD_W), .OUT_W(OUT_W)
   ) u_route (
      .mode(cfg_mode), .din(din), .next_q(next_q),
      .keep_mask(keep_mask), .cov_word(cov_word), .rsvd(rsvd)
   );

   cmdbuf_dreg #(.OUT_W(OUT_W)) u_dreg (
      .clk(clk), .rst_n(rst_n), .frozen(frozen),
      .next_q(next_q), .keep_mask(keep_mask), .q(q_data)
   );

   cmdbuf_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .cke_in(cke_in), .odt_in(odt_in),
      .cs_n({cs1_n, cs0_n}), .rsvd(rsvd),
      .q_cke(q_cke), .q_odt(q_odt), .q_cs(q_cs), .cfg_err(cfg_err)
   );

   cmdbuf_parity #(.DATA_W(DATA_W)) u_par (
      .clk(clk), .rst_n(rst_n), .cov_word(cov_word), .word_sel(!frozen),
      .par_in(par_in), .ppo(ppo), .err_n(err_n)
   );

   AST_DUP_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dup(cfg_mode) && !frozen) |=>
      (q_data[NARROW_W-1:0] == q_data[2*NARROW_W-1:NARROW_W])); // R3

endmodule

// File: tb/tb_cmdbuf_reg.sv
module tb_cmdbuf_reg;

   localparam int DW = 25;
   localparam int NW = 14;
   localparam int CW = 3;
   localparam int OW = 28;
   localparam int NROWS = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    cfg_mode;
   logic          cs0_n, cs1_n, cke_in, odt_in, par_in;
   logic [DW-1:0] din;
   logic [OW-1:0] q_data;
   logic          q_cke, q_odt, ppo, err_n, cfg_err;
   logic [1:0]    q_cs;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   cmdbuf_reg dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cs0_n(cs0_n), .cs1_n(cs1_n),
      .cke_in(cke_in), .odt_in(odt_in), .din(din), .par_in(par_in),
      .q_data(q_data), .q_cke(q_cke), .q_odt(q_odt), .q_cs(q_cs),
      .ppo(ppo), .err_n(err_n), .cfg_err(cfg_err)
   );

   // row layout: mode[31:30] cs1_n cs0_n[29:28] cke odt[27:26] par[25] din[24:0]
   localparam logic [31:0] STIM [NROWS] = '{
      {2'b00, 2'b00, 2'b10, 1'b0, 25'h0ABCDEF},
      {2'b00, 2'b01, 2'b01, 1'b1, 25'h1234567},
      {2'b00, 2'b11, 2'b11, 1'b0, 25'h1FFFFFF},
      {2'b00, 2'b10, 2'b00, 1'b1, 25'h0000001},
      {2'b01, 2'b00, 2'b10, 1'b0, 25'h0003FFF},
      {2'b01, 2'b11, 2'b01, 1'b1, 25'h0002AAA},
      {2'b01, 2'b01, 2'b11, 1'b0, 25'h0001555},
      {2'b11, 2'b00, 2'b00, 1'b1, 25'h0000F0F},
      {2'b11, 2'b11, 2'b10, 1'b0, 25'h00030F0},
      {2'b11, 2'b10, 2'b01, 1'b1, 25'h1F83C1A},
      {2'b10, 2'b00, 2'b10, 1'b0, 25'h0155AA5},
      {2'b00, 2'b11, 2'b00, 1'b1, 25'h0F0F0F0},
      {2'b00, 2'b11, 2'b11, 1'b0, 25'h1111111},
      {2'b00, 2'b00, 2'b01, 1'b1, 25'h0000000},
      {2'b01, 2'b00, 2'b00, 1'b0, 25'h1FFC000},
      {2'b00, 2'b00, 2'b11, 1'b1, 25'h1010101}
   };

   // independent expectation model
   logic [OW-1:0] m_q;
   logic [DW-1:0] m_word;
   logic          m_sel, m_ppo, m_err_n, m_cfg, m_cke, m_odt;
   logic [1:0]    m_cs;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_q = '0; m_word = '0; m_sel = 1'b0; m_ppo = 1'b0; m_err_n = 1'b1;
      m_cfg = 1'b0; m_cke = 1'b0; m_odt = 1'b0; m_cs = 2'b00;
   endtask

   task automatic check_reset_values(input string tag);
      check(tag, {4'h0, q_data}, 32'h0);
      check(tag, {28'h0, q_cke, q_odt, q_cs}, 32'h0);
      check(tag, {29'h0, ppo, err_n, cfg_err}, 32'h2);
   endtask

   task automatic model_edge(input logic [1:0] md, input logic s1, input logic s0,
                             input logic ck, input logic od, input logic p,
                             input logic [DW-1:0] d);
      logic dup, hi, frz, bitx, par;
      dup = md[0];
      hi  = md[0] & md[1];
      frz = s1 & s0;
      if (m_sel) begin
         par = p;
         for (int k = 0; k < DW; k++) par = par ^ m_word[k];
         m_ppo   = par;
         m_err_n = ~par;
      end else begin
         m_err_n = 1'b1;
      end
      for (int i = 0; i < OW; i++) begin
         int j;
         logic keep;
         j = i % NW;
         keep = dup && (hi ? (j >= NW - CW) : (j < CW));
         if (dup) bitx = d[j];
         else     bitx = (i < DW) ? d[i] : 1'b0;
         if (!frz || keep) m_q[i] = bitx;
      end
      for (int k = 0; k < DW; k++) m_word[k] = (dup && k >= NW) ? 1'b0 : d[k];
      m_sel = ~frz;
      m_cke = ck; m_odt = od; m_cs = {s1, s0};
      if (md == 2'b10) m_cfg = 1'b1;
   endtask

   function automatic string qtag(input logic [1:0] md, input logic frz);
      if (frz && md[0]) return "R6";
      if (frz)          return "R5";
      case (md)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b11:   return "R4";
         default: return "R10";
      endcase
   endfunction

   task automatic apply_row(input logic [31:0] r);
      @(negedge clk);
      cfg_mode = r[31:30];
      cs1_n = r[29]; cs0_n = r[28];
      cke_in = r[27]; odt_in = r[26];
      par_in = r[25]; din = r[24:0];
      @(posedge clk);
      model_edge(r[31:30], r[29], r[28], r[27], r[26], r[25], r[24:0]);
      #1;
      check(qtag(r[31:30], r[29] & r[28]), {4'h0, q_data}, {4'h0, m_q});
      check("R7", {28'h0, q_cke, q_odt, q_cs}, {28'h0, m_cke, m_odt, m_cs});
      check("R8", {31'h0, ppo}, {31'h0, m_ppo});
      check("R9", {31'h0, err_n}, {31'h0, m_err_n});
      check("R10", {31'h0, cfg_err}, {31'h0, m_cfg});
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b1;
      cfg_mode = 2'b00; cs0_n = 1'b0; cs1_n = 1'b0;
      cke_in = 1'b0; odt_in = 1'b0; par_in = 1'b0; din = '0;
      #1 rst_n = 1'b0;
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      check_reset_values("R1");
      @(negedge clk);
      rst_n = 1'b1;

      for (int r = 0; r < NROWS; r++) apply_row(STIM[r]);

      // R10: sticky flag survives further flat-mode rows
      apply_row({2'b00, 2'b00, 2'b10, 1'b0, 25'h0C0FFEE});

      // R11: asynchronous clear between edges
      @(negedge clk);
      #1 rst_n = 1'b0;
      #0.5;
      model_reset();
      check_reset_values("R11");
      @(negedge clk);
      rst_n = 1'b1;

      // capture resumes, sticky flag cleared by the reset
      apply_row({2'b00, 2'b01, 2'b11, 1'b0, 25'h1ABCDE5});
      apply_row({2'b01, 2'b00, 2'b00, 1'b1, 25'h0002001});

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule